// File: doc/BRIEF.md
# Infrared Port Register and Receive FIFO Controller

This block is the register-side controller of a fast infrared serial port. A processor reaches it through a simple single-cycle register bus. It keeps three control registers, two status registers and a 64-byte circular receive buffer. On the line side, received bytes come in on a valid/ready stream and transmitted bytes leave on a one-cycle valid strobe. Each direction has its own bit inversion, chosen in control register 2.

Software sets the enables in control 0. It drains received bytes through the data register, which pops the buffer and clears status flags as a side effect. It acknowledges sticky status 0 flags by writing ones to them. A single interrupt line and two DMA request lines (receive and transmit) are derived from status 0 and control 0. These outputs are registered.

Top module: `irport_ctrl`

## Requirements
- R1: After reset every control register, status 0 and the occupancy read as 0. Status 1 reads 0x08. `irq`, `dma_rx_req`, `dma_tx_req`, `tx_valid` and `rx_ready` are low.
- R2: Register offsets are ctrl0 0x00, ctrl1 0x04, ctrl2 0x08, data 0x0C, status0 0x14, status1 0x18 and occupancy 0x1C. Ctrl1 holds 8 bits, and ctrl2 keeps only bits 5:0 (bits 7:6 read 0). Reads of any other offset return 0. Writes to other offsets or to the occupancy register change nothing.
- R3: The receive buffer holds 64 bytes and returns them in arrival order, including across pointer wrap. The occupancy register returns the fill count. `rx_ready` is high only while ctrl0 bit 4 (receive enable) is set and the buffer is not full.
- R4: A received byte is stored as sent when ctrl2 bit 3 is 1, and bit-inverted when it is 0.
- R5: A byte offered while receive is enabled and the buffer is full is dropped. It sets status1 bit 6 and status0 bit 2. Every offered byte while receive is enabled sets status1 bit 4.
- R6: A data read returns the oldest byte and removes it. On an empty buffer it returns 0 and sets status0 bit 1. Either way it clears status0 bit 0 and the status1 bits under mask 0x72.
- R7: A write to status0 clears exactly the bits set in both the written value and 0x66. All other bits keep their value.
- R8: A ctrl0 write with bit 4 = 0 empties the buffer. While bit 4 is 0, offered bytes are neither stored nor flagged.
- R9: While ctrl0 bit 0 (interrupt enable) is 0, status0 reads 0. A write clearing it zeroes status0.
- R10: A data write produces one `tx_valid` pulse in the next cycle only if ctrl0 bits 0 and 3 are both set. The byte is sent as written when ctrl2 bit 2 is 1, and inverted when it is 0.
- R11: `irq` = ctrl0 bit 0 AND (status0 bit 6 OR (ctrl0 bit 2 AND status0 bit 1) OR any status0 bit under 0x25). It is registered and updates on the edge that ends the access.
- R12: `dma_rx_req` follows status0 bit 4, which is interrupt enable AND receive enable AND buffer non-empty. `dma_tx_req` follows status0 bit 3, which is interrupt enable AND transmit enable.
- R13: Each byte stored into the buffer sets status0 bit 0 while the interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational for the current access |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Offered byte will be stored |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The hardest condition to reach from the ports is a full buffer whose read pointer is not at zero, followed by an extra byte that must be dropped. The stimulus first stores and drains five bytes so that the pointers sit away from zero. It then offers 64 bytes, checks that `rx_ready` falls, and offers one more byte to see the overrun flags rise. Finally it drains all 64 bytes and compares them in order against a queue model that applies the receive inversion setting.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int BYTE_W = 8;

  // register offsets
  localparam logic [7:0] OFF_CTRL0 = 8'h00;
  localparam logic [7:0] OFF_CTRL1 = 8'h04;
  localparam logic [7:0] OFF_CTRL2 = 8'h08;
  localparam logic [7:0] OFF_DATA  = 8'h0C;
  localparam logic [7:0] OFF_STAT0 = 8'h14;
  localparam logic [7:0] OFF_STAT1 = 8'h18;
  localparam logic [7:0] OFF_OCC   = 8'h1C;

  // control 0 bits
  localparam int C0_IEN = 0;
  localparam int C0_TUS = 2;
  localparam int C0_TXE = 3;
  localparam int C0_RXE = 4;

  // control 2 bits
  localparam int C2_TXP = 2;
  localparam int C2_RXP = 3;
  localparam logic [7:0] C2_KEEP = 8'h3F;

  // status 0 bits
  localparam int S0_DAV = 0;  // byte stored
  localparam int S0_TUR = 1;  // data read on empty buffer
  localparam int S0_OVR = 2;  // receive overrun
  localparam int S0_TSR = 3;  // transmit service level
  localparam int S0_RSR = 4;  // receive service level
  localparam int S0_EOC = 6;

  // status 1 bits
  localparam int S1_TNF = 3;
  localparam int S1_EOF = 4;
  localparam int S1_ROR = 6;

  localparam logic [7:0] S0_W1C_MASK   = 8'h66;
  localparam logic [7:0] S0_RDCLR_MASK = 8'h01;
  localparam logic [7:0] S0_LEVEL_MASK = 8'h18;
  localparam logic [7:0] S0_IRQ_MASK   = 8'h25;
  localparam logic [7:0] S1_RDCLR_MASK = 8'h72;
  localparam logic [7:0] S1_FIXED_ONE  = 8'h08;
endpackage

// File: rtl/irp_rx_fifo.sv
module irp_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o,
  output logic             full_o,
  output logic             empty_o
);
  // DEPTH must be a power of two: pointers wrap by truncation.
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_nxt, wr_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             do_push, do_pop;

  assign wr_ptr  = rd_q + cnt_q[PTR_W-1:0];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
  assign count_nxt_o = cnt_nxt;

  always_comb begin
    rd_nxt  = rd_q;
    cnt_nxt = cnt_q;
    if (flush_i) begin
      rd_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      if (do_pop) rd_nxt = rd_q + PTR_W'(1);
      cnt_nxt = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  // storage has no reset; only the entry under the write pointer is enabled
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr == PTR_W'(g))) mem[g] <= push_data_i;
    end
  end
endmodule

// File: rtl/irp_status.sv
module irp_status
  import irp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_nxt_i,
  input  logic              tus_nxt_i,
  input  logic              txe_nxt_i,
  input  logic              rxe_nxt_i,
  input  logic              fifo_has_nxt_i,
  input  logic              evt_store_i,
  input  logic              evt_under_i,
  input  logic              evt_drop_i,
  input  logic              evt_rx_i,
  input  logic              data_rd_i,
  input  logic              s0_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] s0_o,
  output logic [BYTE_W-1:0] s1_o,
  output logic              irq_o,
  output logic              dma_rx_o,
  output logic              dma_tx_o
);
  logic [BYTE_W-1:0] s0_q, s0_nxt, s1_q, s1_nxt;
  logic [BYTE_W-1:0] set0, clr0, lvl0, set1, clr1;
  logic              irq_q, irq_nxt, drx_q, dtx_q;

  always_comb begin
    set0 = '0;
    set0[S0_DAV] = evt_store_i;
    set0[S0_TUR] = evt_under_i;
    set0[S0_OVR] = evt_drop_i;
    lvl0 = '0;
    lvl0[S0_TSR] = ien_nxt_i & txe_nxt_i;
    lvl0[S0_RSR] = ien_nxt_i & rxe_nxt_i & fifo_has_nxt_i;
    clr0 = (s0_wr_i ? (wdata_i & S0_W1C_MASK) : '0)
         | (data_rd_i ? S0_RDCLR_MASK : '0);
    // set wins over a clear in the same cycle
    if (ien_nxt_i) s0_nxt = (s0_q & ~clr0 & ~S0_LEVEL_MASK) | set0 | lvl0;
    else           s0_nxt = '0;

    set1 = '0;
    set1[S1_EOF] = evt_rx_i;
    set1[S1_ROR] = evt_drop_i;
    clr1 = data_rd_i ? S1_RDCLR_MASK : '0;
    s1_nxt = (s1_q & ~clr1) | set1;

    irq_nxt = ien_nxt_i & (s0_nxt[S0_EOC]
                         | (tus_nxt_i & s0_nxt[S0_TUR])
                         | (|(s0_nxt & S0_IRQ_MASK)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= '0;
      s1_q  <= '0;
      irq_q <= 1'b0;
      drx_q <= 1'b0;
      dtx_q <= 1'b0;
    end else begin
      s0_q  <= s0_nxt;
      s1_q  <= s1_nxt;
      irq_q <= irq_nxt;
      drx_q <= s0_nxt[S0_RSR];
      dtx_q <= s0_nxt[S0_TSR];
    end
  end

  assign s0_o     = s0_q;
  assign s1_o     = s1_q | S1_FIXED_ONE;
  assign irq_o    = irq_q;
  assign dma_rx_o = drx_q;
  assign dma_tx_o = dtx_q;
endmodule

// File: rtl/irp_tx.sv
module irp_tx
  import irp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ien_i,
  input  logic              txe_i,
  input  logic              txp_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic              v_q, v_nxt;
  logic [BYTE_W-1:0] d_q, d_nxt;

  always_comb begin
    v_nxt = send_i & ien_i & txe_i;
    d_nxt = d_q;
    if (v_nxt) d_nxt = txp_i ? wdata_i : ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else begin
      v_q <= v_nxt;
      d_q <= d_nxt;
    end
  end

  assign tx_valid_o = v_q;
  assign tx_data_o  = d_q;
endmodule

// File: rtl/irport_ctrl.sv
module irport_ctrl
  import irp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // address decode
  logic wr_hit, rd_hit;
  logic sel_c0, sel_c1, sel_c2, sel_data, sel_s0;
  assign wr_hit   = acc_en & acc_wr;
  assign rd_hit   = acc_en & ~acc_wr;
  assign sel_c0   = (acc_addr == ADDR_W'(OFF_CTRL0));
  assign sel_c1   = (acc_addr == ADDR_W'(OFF_CTRL1));
  assign sel_c2   = (acc_addr == ADDR_W'(OFF_CTRL2));
  assign sel_data = (acc_addr == ADDR_W'(OFF_DATA));
  assign sel_s0   = (acc_addr == ADDR_W'(OFF_STAT0));

  // control registers
  logic [7:0] ctrl0_q, ctrl0_nxt, ctrl1_q, ctrl1_nxt, ctrl2_q, ctrl2_nxt;
  always_comb begin
    ctrl0_nxt = ctrl0_q;
    ctrl1_nxt = ctrl1_q;
    ctrl2_nxt = ctrl2_q;
    if (wr_hit && sel_c0) ctrl0_nxt = acc_wdata;
    if (wr_hit && sel_c1) ctrl1_nxt = acc_wdata;
    if (wr_hit && sel_c2) ctrl2_nxt = acc_wdata & C2_KEEP;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      ctrl2_q <= '0;
    end else begin
      ctrl0_q <= ctrl0_nxt;
      ctrl1_q <= ctrl1_nxt;
      ctrl2_q <= ctrl2_nxt;
    end
  end

  // receive path
  logic             rxe, flush, rx_offer, push, pop, data_rd, under, drop;
  logic             fifo_full, fifo_empty;
  logic [7:0]       store_byte, fifo_head;
  logic [CNT_W-1:0] fifo_cnt, fifo_cnt_nxt;

  assign rxe        = ctrl0_q[C0_RXE];
  assign flush      = wr_hit & sel_c0 & ~acc_wdata[C0_RXE];
  assign rx_offer   = rx_valid & rxe;
  assign rx_ready   = rxe & ~fifo_full & ~flush;
  assign push       = rx_offer & rx_ready;
  assign drop       = rx_offer & fifo_full;
  assign store_byte = ctrl2_q[C2_RXP] ? rx_data : ~rx_data;
  assign data_rd    = rd_hit & sel_data;
  assign pop        = data_rd & ~fifo_empty;
  assign under      = data_rd & fifo_empty;

  irp_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_fifo (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (store_byte),
    .pop_i       (pop),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt),
    .count_nxt_o (fifo_cnt_nxt),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  // status and request outputs
  logic [7:0] s0_val, s1_val;
  irp_status i_status (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .ien_nxt_i      (ctrl0_nxt[C0_IEN]),
    .tus_nxt_i      (ctrl0_nxt[C0_TUS]),
    .txe_nxt_i      (ctrl0_nxt[C0_TXE]),
    .rxe_nxt_i      (ctrl0_nxt[C0_RXE]),
    .fifo_has_nxt_i (fifo_cnt_nxt != '0),
    .evt_store_i    (push),
    .evt_under_i    (under),
    .evt_drop_i     (drop),
    .evt_rx_i       (rx_offer),
    .data_rd_i      (data_rd),
    .s0_wr_i        (wr_hit & sel_s0),
    .wdata_i        (acc_wdata),
    .s0_o           (s0_val),
    .s1_o           (s1_val),
    .irq_o          (irq),
    .dma_rx_o       (dma_rx_req),
    .dma_tx_o       (dma_tx_req)
  );

  // transmit path
  irp_tx i_tx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .send_i     (wr_hit & sel_data),
    .wdata_i    (acc_wdata),
    .ien_i      (ctrl0_q[C0_IEN]),
    .txe_i      (ctrl0_q[C0_TXE]),
    .txp_i      (ctrl2_q[C2_TXP]),
    .tx_valid_o (tx_valid),
    .tx_data_o  (tx_data)
  );

  // read mux
  always_comb begin
    case (acc_addr)
      ADDR_W'(OFF_CTRL0): acc_rdata = ctrl0_q;
      ADDR_W'(OFF_CTRL1): acc_rdata = ctrl1_q;
      ADDR_W'(OFF_CTRL2): acc_rdata = ctrl2_q;
      ADDR_W'(OFF_DATA):  acc_rdata = fifo_empty ? 8'h00 : fifo_head;
      ADDR_W'(OFF_STAT0): acc_rdata = s0_val;
      ADDR_W'(OFF_STAT1): acc_rdata = s1_val;
      ADDR_W'(OFF_OCC):   acc_rdata = 8'(fifo_cnt);
      default:            acc_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irport_ctrl_chk.sv
module irport_ctrl_chk
  import irp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic [7:0]        ctrl0_q,
  input logic [7:0]        s0_val,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic              dma_tx_req
);
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr == ADDR_W'(OFF_CTRL0) && !acc_wdata[C0_RXE])
      |=> (fifo_cnt == '0));

  p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl0_q[C0_RXE] |-> !rx_ready);

  p_stat0_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl0_q[C0_IEN] |-> (s0_val == 8'h00));

  p_tx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(ctrl0_q[C0_IEN] && ctrl0_q[C0_TXE]));

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl0_q[C0_IEN]);

  p_dma_tx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req == (ctrl0_q[C0_IEN] && ctrl0_q[C0_TXE]));
endmodule

bind irport_ctrl irport_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata),
  .ctrl0_q    (ctrl0_q),
  .s0_val     (s0_val),
  .fifo_cnt   (fifo_cnt),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .irq        (irq),
  .dma_tx_req (dma_tx_req)
);

// File: tb/test_irport_ctrl.sv
module test_irport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_en, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0]        acc_wdata, acc_rdata;
  logic              rx_valid, rx_ready;
  logic [7:0]        rx_data;
  logic              tx_valid;
  logic [7:0]        tx_data;
  logic              irq, dma_rx_req, dma_tx_req;

  irport_ctrl #(.ADDR_W(ADDR_W)) i_irport_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] tx_exp_q[$];
  logic [7:0] rx_model[$];
  logic [7:0] c2_model = 8'h00;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [ADDR_W-1:0] a,
                     input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
    #1 rd = acc_rdata;
    @(posedge clk);
    #1 acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    bus(1'b1, a, d, dummy);
    if (a == 6'h08) c2_model = d & 8'h3F;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus(1'b0, a, 8'h00, v);
    chk(tag, v, exp);
  endtask

  // data read checked against the receive model
  task automatic rd_data(input string tag);
    logic [7:0] v, exp;
    exp = (rx_model.size() != 0) ? rx_model.pop_front() : 8'h00;
    bus(1'b0, 6'h0C, 8'h00, v);
    chk(tag, v, exp);
  endtask

  // driver: a data write, with its expected line byte pushed to the scoreboard
  task automatic tx_send(input logic [7:0] d, input bit expect_out);
    if (expect_out) tx_exp_q.push_back(c2_model[2] ? d : ~d);
    wr(6'h0C, d);
  endtask

  task automatic rx_offer(input logic [7:0] d, output logic rdy);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #1 rdy = rx_ready;
    if (rdy) rx_model.push_back(c2_model[3] ? d : ~d);
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  // monitor: compares every transmitted byte with the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (tx_exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected tx byte actual 0x%0h expected none", tx_data);
      end else begin
        logic [7:0] e;
        e = tx_exp_q.pop_front();
        if (tx_data !== e) begin
          fails++;
          $display("FAIL R10: tx byte actual 0x%0h expected 0x%0h", tx_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic rdy;
    acc_en = 0; acc_wr = 0; acc_addr = '0; acc_wdata = '0;
    rx_valid = 0; rx_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 dma_rx", dma_rx_req, 0); chk("R1 dma_tx", dma_tx_req, 0);
    chk("R1 rx_ready", rx_ready, 0); chk("R1 tx_valid", tx_valid, 0);
    rd_chk(6'h00, 8'h00, "R1 ctrl0"); rd_chk(6'h04, 8'h00, "R1 ctrl1");
    rd_chk(6'h08, 8'h00, "R1 ctrl2"); rd_chk(6'h14, 8'h00, "R1 stat0");
    rd_chk(6'h18, 8'h08, "R1 stat1"); rd_chk(6'h1C, 8'h00, "R1 occ");
    rd_data("R6 empty read at reset");
    rd_chk(6'h14, 8'h00, "R9 stat0 stays 0 with interrupts off");

    // R2 map and ignored accesses
    wr(6'h04, 8'hA5); rd_chk(6'h04, 8'hA5, "R2 ctrl1");
    wr(6'h08, 8'hFF); rd_chk(6'h08, 8'h3F, "R2 ctrl2 low bits");
    wr(6'h1C, 8'h55); rd_chk(6'h1C, 8'h00, "R2 occ write ignored");
    wr(6'h10, 8'h77); wr(6'h24, 8'h77);
    rd_chk(6'h10, 8'h00, "R2 undefined 0x10"); rd_chk(6'h24, 8'h00, "R2 undefined 0x24");
    rd_chk(6'h00, 8'h00, "R2 ctrl0 untouched"); rd_chk(6'h04, 8'hA5, "R2 ctrl1 untouched");

    // enable all
    wr(6'h08, 8'h0C); wr(6'h00, 8'h19);
    chk("R12 dma_tx", dma_tx_req, 1); chk("R12 dma_rx empty", dma_rx_req, 0);
    chk("R11 irq idle", irq, 0); chk("R3 rx_ready", rx_ready, 1);
    rd_chk(6'h14, 8'h08, "R12 stat0 tx level");

    // R3/R13 receive three bytes
    rx_offer(8'h11, rdy); chk("R3 ready", rdy, 1);
    rx_offer(8'h22, rdy); rx_offer(8'h33, rdy);
    rd_chk(6'h1C, 8'h03, "R3 occ 3");
    rd_chk(6'h14, 8'h19, "R13 stat0 byte flag");
    chk("R11 irq on stored byte", irq, 1); chk("R12 dma_rx", dma_rx_req, 1);
    rd_chk(6'h18, 8'h18, "R5 stat1 eof");
    rd_data("R3 first");
    rd_chk(6'h14, 8'h18, "R6 stat0 bit0 cleared");
    chk("R11 irq cleared", irq, 0);
    rd_chk(6'h18, 8'h08, "R6 stat1 cleared");
    rd_data("R3 second"); rd_data("R3 third");
    chk("R12 dma_rx empty", dma_rx_req, 0);

    // R6 underrun, R11 gating by ctrl0 bit2, R7 write-one-to-clear
    rd_data("R6 empty read");
    rd_chk(6'h14, 8'h0A, "R6 underrun flag");
    chk("R11 underrun masked", irq, 0);
    wr(6'h00, 8'h1D); chk("R11 underrun enabled", irq, 1);
    wr(6'h14, 8'h99); rd_chk(6'h14, 8'h0A, "R7 outside mask kept");
    chk("R7 irq kept", irq, 1);
    wr(6'h14, 8'h02); rd_chk(6'h14, 8'h08, "R7 bit1 cleared");
    chk("R7 irq dropped", irq, 0);

    // R4 receive inversion
    wr(6'h08, 8'h04);
    rx_offer(8'h5A, rdy);
    chk("R11 irq byte", irq, 1);
    rd_data("R4 inverted receive");

    // R10 transmit
    tx_send(8'h3C, 1);
    wr(6'h08, 8'h08);
    tx_send(8'h3C, 1);
    wr(6'h00, 8'h15); chk("R12 dma_tx off", dma_tx_req, 0);
    tx_send(8'h44, 0);
    wr(6'h00, 8'h19);

    // R9 interrupt enable off
    rx_offer(8'h66, rdy);
    rd_chk(6'h14, 8'h19, "R13 byte flag");
    wr(6'h00, 8'h18);
    rd_chk(6'h14, 8'h00, "R9 stat0 zeroed");
    chk("R9 irq", irq, 0); chk("R12 dma_tx gated", dma_tx_req, 0);
    chk("R12 dma_rx gated", dma_rx_req, 0);
    tx_send(8'h55, 0);
    rx_offer(8'h77, rdy);
    rd_chk(6'h14, 8'h00, "R9 stat0 stays 0");
    rd_chk(6'h1C, 8'h02, "R3 occ 2");

    // R8 receive disable flushes and blocks
    wr(6'h00, 8'h08); rx_model.delete();
    rd_chk(6'h1C, 8'h00, "R8 flushed");
    chk("R8 rx_ready low", rx_ready, 0);
    rd_data("R8 empty after flush");
    rd_chk(6'h18, 8'h08, "R6 stat1 cleared by read");
    rx_offer(8'h88, rdy); chk("R8 not ready", rdy, 0);
    rd_chk(6'h1C, 8'h00, "R8 byte ignored");
    rd_chk(6'h18, 8'h08, "R8 no eof flag");

    // R3/R5 wrap, fill and overrun
    wr(6'h00, 8'h19);
    for (int i = 0; i < 5; i++) rx_offer(8'hA0 + 8'(i), rdy);
    for (int i = 0; i < 5; i++) rd_data("R3 pre-wrap");
    for (int i = 0; i < 64; i++) begin
      rx_offer(8'(i), rdy); chk("R3 ready while filling", rdy, 1);
    end
    rd_chk(6'h1C, 8'h40, "R3 full count");
    chk("R3 ready low when full", rx_ready, 0);
    rx_offer(8'hEE, rdy); chk("R5 drop not ready", rdy, 0);
    rd_chk(6'h18, 8'h58, "R5 overrun stat1");
    rd_chk(6'h14, 8'h1D, "R5 overrun stat0");
    chk("R11 irq overrun", irq, 1);
    wr(6'h14, 8'h04); rd_chk(6'h14, 8'h19, "R7 overrun cleared");
    for (int i = 0; i < 64; i++) rd_data("R3 drain order");
    rd_chk(6'h1C, 8'h00, "R3 drained");
    rd_chk(6'h14, 8'h08, "R6 stat0 after drain");
    rd_chk(6'h18, 8'h08, "R6 stat1 after drain");
    chk("R12 dma_rx idle", dma_rx_req, 0);

    repeat (3) @(negedge clk);
    chk("R10 all tx bytes seen", tx_exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule